// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits in front of a block-erasable flash array. It turns bus write cycles into commands and runs the internal state machine that erases and programs the array. An erase takes two bus writes: a setup write and then a confirm write. A running erase can be paused so that other blocks can be read or written, and later resumed. Each block has a lock input that blocks erasure. An 8-bit status register reports whether the engine is ready, whether an erase is paused, and any error conditions. A busy output is high whenever the engine is working.

The array is modelled as a small register file and is cleared to 00h at reset. Bus reads are combinational on `addr`. They return either array data or the status byte, depending on the read mode that the last command selected. Erase time, suspend latency and word-write time are counted in clock cycles, and each is set by a parameter. `NUM_BLOCKS` and `BLOCK_WORDS` must be powers of two.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy is 0, reads return array data (00h in every word), and once the read-status command (70h) is written the status byte reads 80h.
- R2: Writing 20h and then D0h, both with an address in block b, erases block b. Busy stays high for exactly ERASE_CYCLES cycles. Every word of block b then reads FFh and no other block changes.
- R3: After an erase, word-write or suspend sequence is accepted, reads at any address return the status byte. They keep doing so until FFh (read array) is written. 70h also selects status reads.
- R4: Status bit 7 is 0 and busy is 1 exactly while the engine runs an erase, a pending suspend or a word write. Busy only rises in the cycle after a bus write.
- R5: If the write that follows an erase setup carries any data other than D0h, status bits 5 and 4 are set and no erase takes place.
- R6: A confirm to a block whose blk_lock bit is 1 sets status bits 5 and 1. Busy never rises and the block keeps its contents.
- R7: Writing 50h while the engine is idle clears status bits 5, 4 and 1.
- R8: B0h written during an erase suspends it SUSP_LAT cycles later. Status then reads C0h (bits 7 and 6 set), busy drops, and the block keeps its contents.
- R9: 40h followed by an address/data write programs that word after WRITE_CYCLES busy cycles. This works whether the engine is idle or suspended. While a write runs under suspend, status bit 7 is 0 and bit 6 stays 1.
- R10: While suspended, a word write aimed at the suspended block sets status bit 4 and writes nothing. Any command other than FFh, 70h, 50h, 40h or D0h (for example 20h) is ignored and leaves the read mode unchanged.
- R11: D0h written while suspended clears status bits 7 and 6 and raises busy. The erase then finishes after the cycles that remained when it stopped, so the total busy time of the erase is ERASE_CYCLES.
- R12: Bus writes other than B0h-during-erase are ignored while busy is high. An FFh written during an erase leaves reads returning status afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | log2(NUM_BLOCKS*BLOCK_WORDS) | Word address for writes and reads |
| wdata | input | 8 | Command byte or data to program |
| blk_lock | input | NUM_BLOCKS | Per-block erase lock, 1 = locked |
| rdata | output | 8 | Array word or status byte, by read mode |
| busy | output | 1 | High while the engine is working |

## Verification
A counter that slips shows up as a wrong busy length. The random loop and the suspend scenario measure that length in cycles for every erase and write, so an off-by-one shows up within one operation. A wrong suspend flag or error flag shows up on the next status read. A block-select or lock-decode fault leaves a stale or wrongly erased word, and the full array sweep after each random operation reveals it. The checker catches any busy rise without a bus write, a resume that fails to restart the engine, and a lock error without bit 5, all in the cycle they happen.

// File: rtl/fes_pkg.sv
// Shared opcodes and engine state encoding for the flash erase sequencer.
package fes_pkg;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_RD_STATUS   = 8'h70;
    localparam logic [7:0] OP_CLR_STATUS  = 8'h50;
    localparam logic [7:0] OP_RD_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_WORD_WR     = 8'h40;
    localparam logic [7:0] ERASED_BYTE    = 8'hFF;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ERASE = 2'd1,
        ENG_SPEND = 2'd2,
        ENG_WRITE = 2'd3
    } eng_state_t;
endpackage

// File: rtl/fes_array.sv
// Block-organised storage. One word register per address.
// Assumes erase_fire and write_fire never pulse in the same cycle.
module fes_array #(
    parameter int AW          = 5,
    parameter int BLK_BITS    = 2,
    parameter int BLOCK_WORDS = 8,
    localparam int DEPTH      = 1 << AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                erase_fire,
    input  logic [BLK_BITS-1:0] erase_blk,
    input  logic                write_fire,
    input  logic [AW-1:0]       waddr,
    input  logic [7:0]          wdata,
    input  logic [AW-1:0]       rd_addr,
    output logic [7:0]          rd_data
);
    import fes_pkg::*;

    logic [7:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [7:0] word_q;
        // Word storage: cleared at reset, filled on erase of its block, or programmed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= 8'h00;
            else if (erase_fire && erase_blk == BLK_BITS'(g / BLOCK_WORDS))
                word_q <= ERASED_BYTE;
            else if (write_fire && waddr == AW'(g))
                word_q <= wdata;
        end
        assign words[g] = word_q;
    end

    // Combinational read port.
    assign rd_data = words[rd_addr];
endmodule

// File: rtl/fes_engine.sv
// Internal state machine: erase countdown, suspend latency, word-write timing
// and the sticky error flags. Erase progress survives a suspend.
// Assumes ERASE_CYCLES >= 2, SUSP_LAT >= 1, WRITE_CYCLES >= 1.
module fes_engine #(
    parameter int AW           = 5,
    parameter int BLK_BITS     = 2,
    parameter int ERASE_CYCLES = 12,
    parameter int SUSP_LAT     = 3,
    parameter int WRITE_CYCLES = 4,
    localparam int ECW = $clog2(ERASE_CYCLES + 1),
    localparam int LCW = $clog2(SUSP_LAT + 1),
    localparam int WCW = $clog2(WRITE_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_erase,
    input  logic [BLK_BITS-1:0] erase_blk_in,
    input  logic                start_write,
    input  logic [AW-1:0]       waddr_in,
    input  logic [7:0]          wdata_in,
    input  logic                do_suspend,
    input  logic                do_resume,
    input  logic                clr_status,
    input  logic                set_seq_err,
    input  logic                set_lock_err,
    input  logic                set_wr_err,
    output logic                busy,
    output logic                erasing,
    output logic                suspended,
    output logic [BLK_BITS-1:0] eblk,
    output logic [7:0]          status,
    output logic                erase_fire,
    output logic                write_fire,
    output logic [AW-1:0]       waddr,
    output logic [7:0]          wdata
);
    import fes_pkg::*;

    eng_state_t     state;
    logic [ECW-1:0] ecnt;
    logic [LCW-1:0] lcnt;
    logic [WCW-1:0] wcnt;
    logic           err_lock, err_seq, err_erase;

    // Engine sequencing: start, count down, suspend and resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            ecnt      <= '0;
            lcnt      <= '0;
            wcnt      <= '0;
            suspended <= 1'b0;
            eblk      <= '0;
            waddr     <= '0;
            wdata     <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start_erase) begin
                        state <= ENG_ERASE;
                        ecnt  <= ECW'(ERASE_CYCLES);
                        eblk  <= erase_blk_in;
                    end else if (start_write) begin
                        state <= ENG_WRITE;
                        wcnt  <= WCW'(WRITE_CYCLES);
                        waddr <= waddr_in;
                        wdata <= wdata_in;
                    end else if (do_resume) begin
                        state     <= ENG_ERASE;
                        suspended <= 1'b0;
                    end
                end
                ENG_ERASE: begin
                    if (ecnt == ECW'(1)) begin
                        state <= ENG_IDLE;
                    end else begin
                        ecnt <= ecnt - ECW'(1);
                        if (do_suspend) begin
                            state <= ENG_SPEND;
                            lcnt  <= LCW'(SUSP_LAT);
                        end
                    end
                end
                ENG_SPEND: begin
                    if (ecnt == ECW'(1)) begin
                        state <= ENG_IDLE;
                    end else begin
                        ecnt <= ecnt - ECW'(1);
                        if (lcnt == LCW'(1)) begin
                            state     <= ENG_IDLE;
                            suspended <= 1'b1;
                        end else begin
                            lcnt <= lcnt - LCW'(1);
                        end
                    end
                end
                ENG_WRITE: begin
                    if (wcnt == WCW'(1)) state <= ENG_IDLE;
                    else                 wcnt  <= wcnt - WCW'(1);
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Sticky error flags: set by the decoder, cleared by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_lock  <= 1'b0;
            err_seq   <= 1'b0;
            err_erase <= 1'b0;
        end else if (clr_status) begin
            err_lock  <= 1'b0;
            err_seq   <= 1'b0;
            err_erase <= 1'b0;
        end else begin
            if (set_lock_err) begin err_lock <= 1'b1; err_erase <= 1'b1; end
            if (set_seq_err)  begin err_seq  <= 1'b1; err_erase <= 1'b1; end
            if (set_wr_err)   err_seq <= 1'b1;
        end
    end

    // Strobes to the array and the status byte.
    assign busy       = (state != ENG_IDLE);
    assign erasing    = (state == ENG_ERASE);
    assign erase_fire = (state == ENG_ERASE || state == ENG_SPEND) && ecnt == ECW'(1);
    assign write_fire = (state == ENG_WRITE) && wcnt == WCW'(1);
    assign status     = {~busy, suspended, err_erase, err_seq, 2'b00, err_lock, 1'b0};
endmodule

// File: rtl/fes_decoder.sv
// Command decoder: turns bus writes into engine requests and tracks the
// two-cycle sequences and the read mode. Assumes one write strobe per cycle.
module fes_decoder #(
    parameter int NUM_BLOCKS = 4,
    parameter int BLK_BITS   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wdata,
    input  logic [BLK_BITS-1:0]   blk,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    input  logic                  eng_busy,
    input  logic                  eng_erasing,
    input  logic                  suspended,
    input  logic [BLK_BITS-1:0]   susp_blk,
    output logic                  start_erase,
    output logic                  start_write,
    output logic                  do_suspend,
    output logic                  do_resume,
    output logic                  clr_status,
    output logic                  set_seq_err,
    output logic                  set_lock_err,
    output logic                  set_wr_err,
    output logic                  rd_status,
    output logic                  setup_pend,
    output logic                  write_pend
);
    import fes_pkg::*;

    logic nxt_setup, nxt_write, nxt_rd;

    // Command decode for the current bus write.
    always_comb begin
        start_erase = 1'b0; start_write = 1'b0; do_suspend = 1'b0; do_resume = 1'b0;
        clr_status  = 1'b0; set_seq_err = 1'b0; set_lock_err = 1'b0; set_wr_err = 1'b0;
        nxt_setup = setup_pend; nxt_write = write_pend; nxt_rd = rd_status;
        if (wr_en && !eng_busy) begin
            if (setup_pend) begin
                nxt_setup = 1'b0;
                nxt_rd    = 1'b1;
                if (wdata != OP_CONFIRM) set_seq_err  = 1'b1;
                else if (blk_lock[blk])  set_lock_err = 1'b1;
                else                     start_erase  = 1'b1;
            end else if (write_pend) begin
                nxt_write = 1'b0;
                if (suspended && blk == susp_blk) set_wr_err  = 1'b1;
                else                              start_write = 1'b1;
            end else begin
                unique case (wdata)
                    OP_RD_ARRAY:   nxt_rd = 1'b0;
                    OP_RD_STATUS:  nxt_rd = 1'b1;
                    OP_CLR_STATUS: clr_status = 1'b1;
                    OP_ERASE_SETUP: if (!suspended) begin nxt_setup = 1'b1; nxt_rd = 1'b1; end
                    OP_WORD_WR:    begin nxt_write = 1'b1; nxt_rd = 1'b1; end
                    OP_CONFIRM:    if (suspended) begin do_resume = 1'b1; nxt_rd = 1'b1; end
                    default: ;
                endcase
            end
        end else if (wr_en && eng_erasing && wdata == OP_SUSPEND) begin
            do_suspend = 1'b1;
            nxt_rd     = 1'b1;
        end
    end

    // Sequence and read-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_pend <= 1'b0;
            write_pend <= 1'b0;
            rd_status  <= 1'b0;
        end else begin
            setup_pend <= nxt_setup;
            write_pend <= nxt_write;
            rd_status  <= nxt_rd;
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
// Top of the flash erase sequencer: decoder, engine and block array.
// Assumes NUM_BLOCKS and BLOCK_WORDS are powers of two.
module flash_erase_seq #(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_WORDS  = 8,
    parameter int ERASE_CYCLES = 12,
    parameter int SUSP_LAT     = 3,
    parameter int WRITE_CYCLES = 4,
    localparam int BLK_BITS    = $clog2(NUM_BLOCKS),
    localparam int OFF_BITS    = $clog2(BLOCK_WORDS),
    localparam int AW          = BLK_BITS + OFF_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [7:0]            wdata,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    output logic [7:0]            rdata,
    output logic                  busy
);
    logic                start_erase, start_write, do_suspend, do_resume;
    logic                clr_status, set_seq_err, set_lock_err, set_wr_err;
    logic                rd_status, setup_pend, write_pend;
    logic                erasing, suspended, erase_fire, write_fire;
    logic [BLK_BITS-1:0] eblk;
    logic [AW-1:0]       eng_waddr;
    logic [7:0]          eng_wdata, status, arr_rd;

    fes_decoder #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_BITS(BLK_BITS)) u_dec (
        .clk, .rst_n, .wr_en, .wdata,
        .blk(addr[AW-1:OFF_BITS]), .blk_lock,
        .eng_busy(busy), .eng_erasing(erasing), .suspended, .susp_blk(eblk),
        .start_erase, .start_write, .do_suspend, .do_resume, .clr_status,
        .set_seq_err, .set_lock_err, .set_wr_err, .rd_status, .setup_pend, .write_pend
    );

    fes_engine #(
        .AW(AW), .BLK_BITS(BLK_BITS), .ERASE_CYCLES(ERASE_CYCLES),
        .SUSP_LAT(SUSP_LAT), .WRITE_CYCLES(WRITE_CYCLES)
    ) u_eng (
        .clk, .rst_n, .start_erase, .erase_blk_in(addr[AW-1:OFF_BITS]),
        .start_write, .waddr_in(addr), .wdata_in(wdata),
        .do_suspend, .do_resume, .clr_status, .set_seq_err, .set_lock_err, .set_wr_err,
        .busy, .erasing, .suspended, .eblk, .status, .erase_fire, .write_fire,
        .waddr(eng_waddr), .wdata(eng_wdata)
    );

    fes_array #(.AW(AW), .BLK_BITS(BLK_BITS), .BLOCK_WORDS(BLOCK_WORDS)) u_arr (
        .clk, .rst_n, .erase_fire, .erase_blk(eblk), .write_fire,
        .waddr(eng_waddr), .wdata(eng_wdata), .rd_addr(addr), .rd_data(arr_rd)
    );

    // Read mux: status byte or array word.
    assign rdata = rd_status ? status : arr_rd;
endmodule

// File: rtl/fes_chk.sv
// Protocol checker for the flash erase sequencer, bound into the top module.
module fes_chk #(
    parameter int BLK_BITS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          wdata,
    input logic                busy,
    input logic                suspended,
    input logic                setup_pend,
    input logic                write_pend,
    input logic [7:0]          status,
    input logic                write_fire,
    input logic [BLK_BITS-1:0] wblk,
    input logic [BLK_BITS-1:0] eblk
);
    logic cmd_ok;
    assign cmd_ok = wr_en && !busy && !setup_pend && !write_pend;

    // R4
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R6
    lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> status[5]);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && wdata == 8'h50) |=> (!status[5] && !status[4] && !status[1]));

    // R8
    suspend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $fell(busy));

    // R10
    wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (write_fire && suspended) |-> (wblk != eblk));

    // R11
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && suspended && wdata == 8'hD0) |=> (busy && !suspended));
endmodule

bind flash_erase_seq fes_chk #(.BLK_BITS(BLK_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .busy(busy),
    .suspended(suspended), .setup_pend(setup_pend), .write_pend(write_pend),
    .status(status), .write_fire(write_fire),
    .wblk(eng_waddr[AW-1:OFF_BITS]), .eblk(eblk)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
    localparam int NB = 4, BW = 8, NE = 12, SL = 3, WC = 4;
    localparam int DEPTH = NB * BW;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [NB-1:0] blk_lock = '0;
    logic [7:0]    rdata;
    logic          busy;

    int  checks = 0, fails = 0;
    bit  done = 1'b0;
    logic [7:0] mm [DEPTH];
    bit m_susp, m_e5, m_e4, m_e1;

    flash_erase_seq #(.NUM_BLOCKS(NB), .BLOCK_WORDS(BW), .ERASE_CYCLES(NE),
                      .SUSP_LAT(SL), .WRITE_CYCLES(WC)) uut (
        .clk, .rst_n, .wr_en, .addr, .wdata, .blk_lock, .rdata, .busy);

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_st(bit rdy);
        return {rdy, m_susp, m_e5, m_e4, 2'b00, m_e1, 1'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic check_status(string req);
        logic [7:0] d;
        bus_wr('0, 8'h70);
        rd('0, d);
        check(req, d, exp_st(1'b1));
    endtask

    task automatic verify_array(string req);
        logic [7:0] d;
        bus_wr('0, 8'hFF);
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), d);
            check(req, d, mm[a]);
        end
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [7:0] d);
        int n;
        bus_wr(a, 8'h40);
        bus_wr(a, d);
        count_busy(n);
        check("R9 write busy", n, WC);
        mm[a] = d;
    endtask

    task automatic do_erase(int b);
        int n;
        logic [7:0] d;
        bit lk = blk_lock[b];
        bus_wr(AW'(b * BW), 8'h20);
        bus_wr(AW'(b * BW + int'($urandom % BW)), 8'hD0);
        count_busy(n);
        if (lk) begin
            check("R6 locked no busy", n, 0);
            m_e1 = 1'b1; m_e5 = 1'b1;
        end else begin
            check("R2 erase busy", n, NE);
            for (int i = 0; i < BW; i++) mm[b * BW + i] = 8'hFF;
        end
        rd(AW'($urandom % DEPTH), d);
        check("R3 status after erase", d, exp_st(1'b1));
    endtask

    initial begin
        logic [7:0] d;
        int n, k, dly, pre;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) mm[i] = 8'h00;
        m_susp = 0; m_e5 = 0; m_e4 = 0; m_e1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", busy, 0);
        rd(5'd9, d);
        check("R1 array read", d, 8'h00);
        check_status("R1 status");

        // Fill a few words
        for (int i = 0; i < DEPTH; i += 3) do_write(AW'(i), 8'(i * 7 + 1));
        verify_array("R9 fill");

        // R12: FFh written during erase is ignored
        blk_lock = '0;
        bus_wr(5'd8, 8'h20);
        bus_wr(5'd9, 8'hD0);
        bus_wr(5'd0, 8'hFF);
        count_busy(n);
        rd(5'd3, d);
        check("R12 mode kept", d, exp_st(1'b1));
        for (int i = 0; i < BW; i++) mm[8 + i] = 8'hFF;
        verify_array("R2 block1 erased");

        // R5: bad confirm
        bus_wr(5'd16, 8'h20);
        bus_wr(5'd16, 8'h70);
        check("R5 no busy", busy, 0);
        m_e4 = 1; m_e5 = 1;
        rd(5'd16, d);
        check("R5 status", d, exp_st(1'b1));
        verify_array("R5 unchanged");
        // R7: clear
        bus_wr('0, 8'h50);
        m_e4 = 0; m_e5 = 0;
        check_status("R7 cleared");

        // R6: locked erase
        blk_lock = 4'b0100;
        do_erase(2);
        check_status("R6 status");
        verify_array("R6 unchanged");
        bus_wr('0, 8'h50);
        m_e1 = 0; m_e5 = 0;
        blk_lock = '0;

        // R8/R9/R10/R11: suspend scenario on block 0
        mm[0] = 8'h11; mm[20] = 8'h22;
        do_write(5'd0, 8'h11);
        do_write(5'd20, 8'h22);
        dly = int'($urandom % 4);
        bus_wr(5'd1, 8'h20);
        bus_wr(5'd2, 8'hD0);
        repeat (dly) @(negedge clk);
        bus_wr(5'd0, 8'hB0);
        k = 2 + dly;
        count_busy(n);
        check("R8 suspend latency", n, SL);
        m_susp = 1;
        rd(5'd0, d);
        check("R8 status C0", d, exp_st(1'b1));
        verify_array("R8 block kept");
        // R10: 20h ignored, mode stays array
        bus_wr(5'd9, 8'h20);
        rd(5'd20, d);
        check("R10 20h ignored", d, 8'h22);
        // R10: write to suspended block
        bus_wr(5'd3, 8'h40);
        bus_wr(5'd3, 8'h3C);
        check("R10 no busy", busy, 0);
        m_e4 = 1;
        rd(5'd3, d);
        check("R10 status", d, exp_st(1'b1));
        bus_wr('0, 8'h50);
        m_e4 = 0;
        check_status("R7 clear in suspend");
        // R9: write to another block while suspended
        bus_wr(5'd21, 8'h40);
        bus_wr(5'd21, 8'hA5);
        rd(5'd21, d);
        check("R9 status during write", d, exp_st(1'b0));
        count_busy(n);
        check("R9 suspended write busy", n, WC);
        mm[21] = 8'hA5;
        verify_array("R9 suspended write data");
        // R11: resume
        bus_wr(5'd0, 8'hD0);
        m_susp = 0;
        rd(5'd0, d);
        check("R11 status on resume", d, exp_st(1'b0));
        count_busy(n);
        pre = k + SL;
        check("R11 remaining cycles", n, NE - pre);
        for (int i = 0; i < BW; i++) mm[i] = 8'hFF;
        check_status("R11 status after");
        verify_array("R11 block0 erased");

        // Random phase
        for (int it = 0; it < 30; it++) begin
            int op = int'($urandom % 4);
            case (op)
                0, 1: do_write(AW'($urandom % DEPTH), 8'($urandom));
                2: begin
                    blk_lock = NB'($urandom);
                    do_erase(int'($urandom % NB));
                    blk_lock = '0;
                end
                default: begin
                    logic [7:0] bd = 8'($urandom);
                    if (bd == 8'hD0) bd = 8'h00;
                    bus_wr(AW'($urandom % DEPTH), 8'h20);
                    bus_wr(AW'($urandom % DEPTH), bd);
                    check("R5 random no busy", busy, 0);
                    m_e4 = 1; m_e5 = 1;
                end
            endcase
            check_status("R4 random status");
            if ($urandom % 2 == 0) begin
                bus_wr('0, 8'h50);
                m_e1 = 0; m_e4 = 0; m_e5 = 0;
            end
            verify_array("R2 random array");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule